// File: doc/BRIEF.md
# Scan Test Cycle Sequencer

This controller runs structural scan test on a single scan chain of `CHAIN_LEN` cells. It drives the chain's scan-enable and a clock enable for the chain. It takes one stream of beats from a pattern source, and each beat carries a stimulus bit and a golden bit. For every pattern it shifts the stimulus into the chain head. It then lowers scan-enable for a single capture clock, so every cell takes its functional input. The response is shifted out of the chain tail and checked bit by bit against the golden stream.

The response of one pattern is unloaded in the same beats that load the next pattern. A run of P patterns therefore takes (P+1)·N shift beats and P capture cycles. The first N beats only load, so their golden bits are ignored. The last N beats only unload, and during them the head is fed with zeros. After each unload a one-cycle verdict is reported, and a sticky fail flag summarises the whole run.

The source interface is valid/ready. `src_ready` is high in every shift state, whether or not `src_valid` is high. A beat transfers on a clock where both are high. When the source withholds `src_valid`, the chain clock enable stays low, so the chain and the sequencer hold their state. The sequencer never has to wait on the chain, and `src_ready` is low during capture, idle and done.

Top module: `scan_seq`

## Requirements
- R1: After reset, `done`, `src_ready`, `shift_ce`, `result_valid`, `result_fail` and `any_fail` are 0 and `scan_en` is 1.
- R2: After `start` with a non-zero `pattern_count`, the first N accepted beats load the chain with `scan_en`=1. Their golden bits are never compared.
- R3: After every N accepted beats in a load or exchange phase, exactly one cycle follows with `scan_en`=0 and `shift_ce`=1. A run of P patterns has exactly P such cycles.
- R4: Unloading a pattern and loading the next one share the same beats. A run of P patterns accepts exactly (P+1)·N beats.
- R5: In a shift state, `src_ready` is 1 and `shift_ce` equals `src_valid`. With `src_valid`=0 the chain does not move. `src_ready` is 0 in the capture cycle.
- R6: In an unload beat, `scan_out` is compared with `src_gold`, with the first emerged bit matched to the first golden bit of that unload. `result_valid` pulses for one cycle, the cycle after the last unload beat of each pattern, with patterns in order. `result_fail` is 1 in that cycle exactly when any bit of that pattern mismatched.
- R7: During the final unload, `scan_in` is 0 whatever `src_stim` carries, so the chain is all zeros at `done`.
- R8: `any_fail` becomes 1 with the first failing verdict and stays 1 until the next `start`, which clears it. `done` stays 1 until the next `start`.
- R9: A `start` with `pattern_count`=0 reaches `done` on the next cycle without accepting a beat.
- R10: A single-cell stuck-at-0 fault in the captured logic is reported as failing on exactly those patterns whose fault-free response differs at that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted in idle or done |
| pattern_count | input | CNT_W | Number of patterns in the run |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | Sequencer accepts a beat |
| src_stim | input | 1 | Stimulus bit of the beat |
| src_gold | input | 1 | Expected response bit of the beat |
| scan_en | output | 1 | Chain shifts when 1, captures when 0 |
| shift_ce | output | 1 | Chain clock enable |
| scan_in | output | 1 | Bit into the chain head |
| scan_out | input | 1 | Bit from the chain tail |
| done | output | 1 | Run finished |
| result_valid | output | 1 | Per-pattern verdict strobe |
| result_fail | output | 1 | Verdict: pattern mismatched |
| any_fail | output | 1 | Sticky fail over the run |

## Verification
Two things land close together. The compare of a pattern's last unload bit happens on the same beat that loads the last stimulus bit of the next pattern. Its registered verdict then appears in the same cycle as the following capture. The bench flips only the final golden bit of one pattern in the middle of a run. It then expects a fail on that pattern and a pass on its neighbour, which shows the mismatch accumulator closes and clears on the right beat. Random gaps in `src_valid` move these coincidences relative to stalls, and each verdict is judged against a response model of the chain kept in the bench.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CAPTURE,
    ST_XCHG,
    ST_FLUSH,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 64,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pattern_count,
  input  logic             beat,
  output seq_state_t       state,
  output logic             last_beat
);
  localparam int BW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BW-1:0] LAST_IDX = BW'(CHAIN_LEN - 1);

  logic [BW-1:0]    bit_cnt;
  logic [CNT_W-1:0] pat_left;   // patterns still to be loaded

  assign last_beat = beat && (bit_cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      pat_left <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            bit_cnt <= '0;
            if (pattern_count == '0) begin
              state <= ST_DONE;
            end else begin
              state    <= ST_LOAD;
              pat_left <= pattern_count - 1'b1;
            end
          end
        end
        ST_LOAD, ST_XCHG, ST_FLUSH: begin
          if (beat) begin
            if (last_beat) begin
              bit_cnt <= '0;
              state   <= (state == ST_FLUSH) ? ST_DONE : ST_CAPTURE;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_CAPTURE: begin
          if (pat_left == '0) begin
            state <= ST_FLUSH;
          end else begin
            state    <= ST_XCHG;
            pat_left <= pat_left - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_seq_cmp.sv
module scan_seq_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cmp_en,
  input  logic cmp_last,
  input  logic scan_out,
  input  logic gold,
  output logic result_valid,
  output logic result_fail,
  output logic any_fail
);
  logic err_acc;
  logic mism;
  logic verdict;

  assign mism    = cmp_en && (scan_out != gold);
  assign verdict = err_acc || mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_acc      <= 1'b0;
      result_valid <= 1'b0;
      result_fail  <= 1'b0;
      any_fail     <= 1'b0;
    end else begin
      result_valid <= cmp_en && cmp_last;
      result_fail  <= cmp_en && cmp_last && verdict;
      if (clear) begin
        err_acc  <= 1'b0;
        any_fail <= 1'b0;
      end else if (cmp_en) begin
        err_acc <= cmp_last ? 1'b0 : verdict;
        if (cmp_last && verdict) any_fail <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 64,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pattern_count,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic             src_stim,
  input  logic             src_gold,
  output logic             scan_en,
  output logic             shift_ce,
  output logic             scan_in,
  input  logic             scan_out,
  output logic             done,
  output logic             result_valid,
  output logic             result_fail,
  output logic             any_fail
);
  seq_state_t state;
  logic       last_beat;
  logic       shifting;
  logic       beat;
  logic       unloading;
  logic       idle_like;

  assign shifting  = (state == ST_LOAD) || (state == ST_XCHG) || (state == ST_FLUSH);
  assign unloading = (state == ST_XCHG) || (state == ST_FLUSH);
  assign idle_like = (state == ST_IDLE) || (state == ST_DONE);
  assign beat      = shifting && src_valid;

  assign src_ready = shifting;
  assign scan_en   = (state != ST_CAPTURE);
  assign shift_ce  = beat || (state == ST_CAPTURE);
  assign scan_in   = (state == ST_FLUSH) ? 1'b0 : src_stim;
  assign done      = (state == ST_DONE);

  scan_seq_fsm #(
    .CHAIN_LEN(CHAIN_LEN),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .pattern_count(pattern_count),
    .beat         (beat),
    .state        (state),
    .last_beat    (last_beat)
  );

  scan_seq_cmp u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start && idle_like),
    .cmp_en      (beat && unloading),
    .cmp_last    (last_beat),
    .scan_out    (scan_out),
    .gold        (src_gold),
    .result_valid(result_valid),
    .result_fail (result_fail),
    .any_fail    (any_fail)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic src_valid,
  input logic src_ready,
  input logic scan_en,
  input logic shift_ce,
  input logic done,
  input logic result_valid,
  input logic result_fail,
  input logic any_fail
);
  a_r3_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> scan_en);
  a_r3_capture_clocked: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> shift_ce);
  a_r5_ce_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && shift_ce) |-> (src_valid && src_ready));
  a_r5_no_ready_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |-> !src_ready);
  a_r6_verdict_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  a_r6_fail_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    result_fail |-> result_valid);
  a_r8_any_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (any_fail && !start) |=> any_fail);
  a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

bind scan_seq scan_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .src_valid   (src_valid),
  .src_ready   (src_ready),
  .scan_en     (scan_en),
  .shift_ce    (shift_ce),
  .done        (done),
  .result_valid(result_valid),
  .result_fail (result_fail),
  .any_fail    (any_fail)
);

// File: tb/scan_seq_tb.sv
module scan_seq_tb;
  localparam int N  = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] pattern_count = '0;
  logic src_valid = 1'b0, src_stim = 1'b0, src_gold = 1'b0;
  logic src_ready, scan_en, shift_ce, scan_in, done;
  logic result_valid, result_fail, any_fail;
  logic [N-1:0] chain;   // chain[0] is the head, chain[N-1] the tail
  logic fault_en = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  scan_seq #(.CHAIN_LEN(N), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern_count(pattern_count),
    .src_valid(src_valid), .src_ready(src_ready), .src_stim(src_stim),
    .src_gold(src_gold), .scan_en(scan_en), .shift_ce(shift_ce),
    .scan_in(scan_in), .scan_out(chain[N-1]), .done(done),
    .result_valid(result_valid), .result_fail(result_fail), .any_fail(any_fail)
  );

  function automatic logic [N-1:0] f_good(input logic [N-1:0] v);
    logic [N-1:0] d;
    for (int i = 0; i < N; i++) d[i] = v[i] ^ v[(i + 1) % N];
    return d;
  endfunction

  function automatic logic [N-1:0] f_cap(input logic [N-1:0] v, input logic flt);
    logic [N-1:0] d;
    d = f_good(v);
    if (flt) d[1] = 1'b0;   // stuck-at-0 on cell 1
    return d;
  endfunction

  always @(posedge clk) begin
    if (shift_ce) begin
      if (scan_en) chain <= {chain[N-2:0], scan_in};
      else         chain <= f_cap(chain, fault_en);
    end
  end

  int errors = 0, checks = 0;
  int beats = 0, caps = 0, since = 0, ridx = 0;
  bit running = 1'b0;
  logic [N-1:0] vec [0:15];
  logic [N-1:0] flip [0:15];
  bit expf [0:15];
  int valid_pct = 100;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (src_ready && !src_valid) chk(!shift_ce, "R5 stall holds chain", shift_ce, 0);
      if (src_valid && src_ready) begin beats++; since++; end
      if (!scan_en) begin
        caps++;
        chk(shift_ce, "R3 capture clock enable", shift_ce, 1);
        chk(since == N, "R3 beats before capture", since, N);
        since = 0;
      end
      if (result_valid) begin
        chk(result_fail == expf[ridx], "R6 R10 pattern verdict", result_fail, expf[ridx]);
        ridx++;
      end
    end
  end

  task automatic run(input int p, input bit flt, input int vpct);
    bit exp_any;
    fault_en = flt; valid_pct = vpct;
    exp_any = 1'b0;
    for (int i = 0; i < p; i++) begin
      expf[i] = (f_cap(vec[i], flt) != (f_good(vec[i]) ^ flip[i]));
      exp_any |= expf[i];
    end
    @(negedge clk);
    beats = 0; caps = 0; since = 0; ridx = 0; running = 1'b1;
    start = 1'b1; pattern_count = CW'(p);
    @(negedge clk);
    start = 1'b0;
    chk(any_fail == 1'b0, "R8 start clears any_fail", any_fail, 0);
    for (int k = 0; k < (p + 1) * N; k++) begin
      int blk, j;
      blk = k / N; j = k % N;
      forever begin
        src_valid = ($urandom % 100) < valid_pct;
        src_stim  = (blk < p) ? vec[blk][N-1-j] : 1'b1;
        src_gold  = (blk > 0) ? (f_good(vec[blk-1]) ^ flip[blk-1]) >> (N-1-j) : 1'($urandom);
        if (src_valid && src_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    src_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    running = 1'b0;
    chk(beats == (p + 1) * N, "R4 total beats", beats, (p + 1) * N);
    chk(caps == p, "R3 capture count", caps, p);
    chk(ridx == p, "R6 verdict count", ridx, p);
    chk(chain == '0, "R7 flush shifts zeros", chain, 0);
    chk(any_fail == exp_any, "R8 sticky any_fail", any_fail, exp_any);
    repeat (3) @(negedge clk);
    chk(done && any_fail == exp_any, "R8 done and any_fail held", done, 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    chain = '0;
    repeat (3) @(negedge clk);
    chk(!done && !src_ready && !shift_ce && scan_en && !result_valid && !result_fail && !any_fail,
        "R1 reset outputs", {done, src_ready, shift_ce, scan_en}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: zero patterns from idle
    start = 1'b1; pattern_count = '0;
    @(negedge clk);
    start = 1'b0;
    chk(done && !src_ready, "R9 zero patterns done", done, 1);

    // R2 R4 R5: random patterns, random valid gaps, no fault; load golden is random
    for (int i = 0; i < 16; i++) begin vec[i] = N'($urandom); flip[i] = '0; end
    run(5, 1'b0, 65);

    // R6: directed vector 1011, last emitted bit of pattern 1 corrupted
    vec[0] = 4'b1011; vec[1] = 4'b0110; vec[2] = 4'b1100;
    flip[1] = 4'b0001;
    run(3, 1'b0, 80);
    flip[1] = '0;

    // R10: stuck-at fault in captured logic, random vectors
    for (int i = 0; i < 16; i++) vec[i] = N'($urandom);
    vec[0] = 4'b0011;   // good response has cell 1 set
    run(6, 1'b1, 70);

    // R8 R9: zero-count start from done clears any_fail
    start = 1'b1; pattern_count = '0;
    @(negedge clk);
    start = 1'b0;
    chk(done && !any_fail, "R9 R8 zero run clears any_fail", any_fail, 0);

    // back-to-back beats, single pattern, no gaps
    vec[0] = 4'b1111;
    run(1, 1'b0, 100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule